// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block takes one input clock and derives from it an output clock that can be divided, frozen and cleared. A 3-bit code sets the division ratio from 1 to 8. Deasserting the run enable stops the output at whatever level it is at, and the phase is kept, so the output resumes exactly where it stopped. Asserting the clear pulls the output low at once and restarts the division from the beginning of a period. Two mask inputs can override the controls: one makes the enable count as asserted, the other makes the clear count as inactive.

Both edges of the enable and the release of the clear pass through two-stage synchronizers clocked by the input clock. The enable and the clear can therefore come from any clock domain, and the output never carries a shortened pulse. A new ratio code is taken only when the current output period ends. Ratio 1 passes the input clock straight through. That path is opened and closed by a gate register that changes only while the input clock is low.

Top module: `gclk_divider`

## Requirements
- R1: While `rst_n` is low, or while `clr` is high with `clr_mask` low, `clk_out` is 0. The clear drives the output low at once, without waiting for an input clock edge.
- R2: For `div_code` = c with c from 1 to 7, the ratio is N = c+1. Each output period lasts N input cycles: first high for floor(N/2) cycles, then low for the remaining ceil(N/2) cycles.
- R3: For `div_code` = 0 (ratio 1), `clk_out` follows `clk_in` while the block is running: it is high whenever the input clock is high.
- R4: After the clear is released with the enable active, the counter takes its first step on the third rising edge of `clk_in` after the release. The first output transition is a rising edge.
- R5: When the enable drops, the divider still advances on the next two rising edges of `clk_in`. From the third edge on, it holds its level (high or low) and its phase.
- R6: When the enable returns, the divider resumes from the held phase. It takes its first step on the third rising edge of `clk_in` after the change.
- R7: With `ce_mask` high, the enable counts as asserted whatever level `ce` has.
- R8: With `clr_mask` high, a high `clr` has no effect: the output keeps its period and phase.
- R9: A change of `div_code` while running takes effect only when the counter wraps to the start of a new period. The period in progress completes at the old ratio.
- R10: With ratio 1 and the enable inactive, `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear: output low, division restarts |
| clr_mask | input | 1 | When high, `clr` is ignored |
| ce | input | 1 | Run enable; low freezes the output |
| ce_mask | input | 1 | When high, the enable counts as asserted |
| div_code | input | 3 | Ratio code, ratio = code + 1 |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
A phase counter that is off by one, or a wrong high length, appears within one output period as a high or low run of the wrong length. A ratio latched at the wrong moment stretches or cuts the period in which the code changes. A synchronizer with the wrong depth moves the first output step after a clear release, or the last step before a freeze, by one input cycle. The cycle-exact scoreboard catches that shift on the first sample after the event. A bypass gate that is set wrongly shows up at once as a missing or extra high sample while ratio 1 is selected.

// File: rtl/gcd_pkg.sv
`timescale 1ns/1ps
package gcd_pkg;
  // Default width of the ratio code; ratio = code + 1.
  localparam int DIV_W_DEF  = 3;
  // Default depth of the control synchronizers.
  localparam int SYNC_DEF   = 2;
endpackage

// File: rtl/gcd_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer with asynchronous clear to 0.
module gcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sq_q;
  logic [STAGES-1:0] sq_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sq_d = d;
    end else begin : g_chain
      always_comb sq_d = {sq_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk_in or negedge arst_n) begin
    if (!arst_n) sq_q <= '0;
    else         sq_q <= sq_d;
  end

  assign q = sq_q[STAGES-1];
endmodule

// File: rtl/gcd_ctrl.sv
`timescale 1ns/1ps
// Control conditioning: masks, enable synchronizer, clear release synchronizer.
module gcd_ctrl #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic clr,
  input  logic clr_mask,
  input  logic ce,
  input  logic ce_mask,
  output logic run_q,
  output logic clr_done,
  output logic clr_arst_n
);
  logic clr_eff;
  logic ce_eff;

  assign clr_eff    = clr & ~clr_mask;
  assign ce_eff     = ce | ce_mask;
  // Clear asserts asynchronously, together with the block reset.
  assign clr_arst_n = rst_n & ~clr_eff;

  gcd_sync #(.STAGES(STAGES)) u_ce_sync (
    .clk_in (clk_in),
    .arst_n (rst_n),
    .d      (ce_eff),
    .q      (run_q)
  );

  // Release of the clear travels through the chain as a rising level.
  gcd_sync #(.STAGES(STAGES)) u_clr_sync (
    .clk_in (clk_in),
    .arst_n (clr_arst_n),
    .d      (1'b1),
    .q      (clr_done)
  );
endmodule

// File: rtl/gcd_counter.sv
`timescale 1ns/1ps
// Phase counter with ratio latch at wrap and registered divided output.
module gcd_counter #(
  parameter int DIV_W = 3
) (
  input  logic             clk_in,
  input  logic             arst_n,
  input  logic             clr_done,
  input  logic             run_q,
  input  logic [DIV_W-1:0] div_code,
  output logic [DIV_W:0]   cnt_q,
  output logic [DIV_W:0]   ratio_q,
  output logic             out_q,
  output logic             bypass_nx
);
  localparam int RW = DIV_W + 1;

  logic [RW-1:0] new_ratio;
  logic [RW-1:0] cnt_inc;
  logic [RW-1:0] ratio_nx;
  logic [RW-1:0] cnt_d;
  logic [RW-1:0] ratio_d;
  logic          out_d;
  logic          wrap;

  assign new_ratio = {1'b0, div_code} + RW'(1);
  assign cnt_inc   = cnt_q + RW'(1);
  assign wrap      = (cnt_q == ratio_q - RW'(1));
  assign ratio_nx  = wrap ? new_ratio : ratio_q;
  // Ratio that will govern the next rising edge, for the bypass gate.
  assign bypass_nx = clr_done & run_q & (ratio_nx == RW'(1));

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    out_d   = out_q;
    if (!clr_done) begin
      // Preset to the last phase so the first step wraps to a high phase.
      ratio_d = new_ratio;
      cnt_d   = {1'b0, div_code};
      out_d   = 1'b0;
    end else if (run_q) begin
      if (wrap) begin
        ratio_d = new_ratio;
        cnt_d   = '0;
        out_d   = (new_ratio >> 1) != '0;
      end else begin
        cnt_d   = cnt_inc;
        out_d   = cnt_inc < (ratio_q >> 1);
      end
    end
  end

  always_ff @(posedge clk_in or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      ratio_q <= RW'(1);
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      out_q   <= out_d;
    end
  end
endmodule

// File: rtl/gcd_outstage.sv
`timescale 1ns/1ps
// Output stage: bypass gate updated while the input clock is low.
module gcd_outstage (
  input  logic clk_in,
  input  logic arst_n,
  input  logic bypass_nx,
  input  logic div_out,
  output logic clk_out
);
  logic gate_q;

  always_ff @(negedge clk_in or negedge arst_n) begin
    if (!arst_n) gate_q <= 1'b0;
    else         gate_q <= bypass_nx;
  end

  assign clk_out = (gate_q & clk_in) | div_out;
endmodule

// File: rtl/gclk_divider.sv
`timescale 1ns/1ps
module gclk_divider #(
  parameter int DIV_W  = gcd_pkg::DIV_W_DEF,
  parameter int STAGES = gcd_pkg::SYNC_DEF
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             clr_mask,
  input  logic             ce,
  input  logic             ce_mask,
  input  logic [DIV_W-1:0] div_code,
  output logic             clk_out
);
  logic           run_q;
  logic           clr_done;
  logic           clr_arst_n;
  logic [DIV_W:0] cnt_q;
  logic [DIV_W:0] ratio_q;
  logic           out_q;
  logic           bypass_nx;

  gcd_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .clr        (clr),
    .clr_mask   (clr_mask),
    .ce         (ce),
    .ce_mask    (ce_mask),
    .run_q      (run_q),
    .clr_done   (clr_done),
    .clr_arst_n (clr_arst_n)
  );

  gcd_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_in    (clk_in),
    .arst_n    (clr_arst_n),
    .clr_done  (clr_done),
    .run_q     (run_q),
    .div_code  (div_code),
    .cnt_q     (cnt_q),
    .ratio_q   (ratio_q),
    .out_q     (out_q),
    .bypass_nx (bypass_nx)
  );

  gcd_outstage u_out (
    .clk_in    (clk_in),
    .arst_n    (clr_arst_n),
    .bypass_nx (bypass_nx),
    .div_out   (out_q),
    .clk_out   (clk_out)
  );
endmodule

// File: rtl/gcd_checker.sv
`timescale 1ns/1ps
module gcd_checker #(
  parameter int DIV_W = 3
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic             clr,
  input logic             clr_mask,
  input logic             clk_out,
  input logic             run_q,
  input logic             clr_done,
  input logic             out_q,
  input logic [DIV_W:0]   cnt_q,
  input logic [DIV_W:0]   ratio_q,
  input logic [DIV_W-1:0] div_code
);
  // R1: an active clear keeps the output low
  a_r1_clear_low: assert property (@(posedge clk_in) disable iff (!rst_n)
    (clr && !clr_mask) |-> !clk_out);

  // R2: the phase never reaches the ratio
  a_r2_phase_in_range: assert property (@(posedge clk_in)
    disable iff (!rst_n || (clr && !clr_mask))
    clr_done |-> (cnt_q < ratio_q));

  // R4: the first step after the release produces a high phase
  a_r4_first_edge_rises: assert property (@(posedge clk_in)
    disable iff (!rst_n || (clr && !clr_mask))
    ($rose(clr_done) && run_q && (div_code != '0)) |=> out_q);

  // R5: a frozen divider keeps phase and level
  a_r5_freeze_holds: assert property (@(posedge clk_in)
    disable iff (!rst_n || (clr && !clr_mask))
    (clr_done && !run_q) |=> ($stable(cnt_q) && $stable(out_q)));

  // R9: the ratio only changes when a new period starts
  a_r9_ratio_at_wrap: assert property (@(posedge clk_in)
    disable iff (!rst_n || (clr && !clr_mask))
    ($past(clr_done) && !$stable(ratio_q)) |-> (cnt_q == '0));
endmodule

bind gclk_divider gcd_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_in   (clk_in),
  .rst_n    (rst_n),
  .clr      (clr),
  .clr_mask (clr_mask),
  .clk_out  (clk_out),
  .run_q    (run_q),
  .clr_done (clr_done),
  .out_q    (out_q),
  .cnt_q    (cnt_q),
  .ratio_q  (ratio_q),
  .div_code (div_code)
);

// File: tb/sim_gclk_divider.sv
`timescale 1ns/1ps
module sim_gclk_divider;
  logic       clk;
  logic       rst_n;
  logic       clr;
  logic       clr_mask;
  logic       ce;
  logic       ce_mask;
  logic [2:0] div_code;
  logic       clk_out;

  int checks;
  int errors;
  bit finished;

  typedef struct {
    logic  v;
    string req;
  } exp_t;
  exp_t sb_q[$];

  // Expected-behaviour state built from the requirements.
  int m_s1, m_s2, m_r1, m_r2, m_n, m_ph;

  gclk_divider u0 (
    .clk_in   (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .clr_mask (clr_mask),
    .ce       (ce),
    .ce_mask  (ce_mask),
    .div_code (div_code),
    .clk_out  (clk_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  task automatic chk(input logic act, input logic expv, input string req);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: clk_out=%0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  // Compute the expected output for the next sample from the driven inputs.
  task automatic model_push(input string req);
    exp_t it;
    logic e;
    int   stp;
    if (clr && !clr_mask) begin
      m_s1 = 0; m_s2 = 0;
      m_n = int'(div_code) + 1; m_ph = m_n - 1;
      e = 1'b0;
    end else begin
      stp = m_s2 & m_r2;
      if (m_s2 == 0) begin
        m_n = int'(div_code) + 1; m_ph = m_n - 1;
      end else if (stp != 0) begin
        if (m_ph == m_n - 1) begin
          m_ph = 0; m_n = int'(div_code) + 1;
        end else begin
          m_ph++;
        end
      end
      if (m_n == 1) e = (stp != 0);
      else          e = (m_ph < m_n / 2);
      m_s2 = m_s1; m_s1 = 1;
    end
    m_r2 = m_r1;
    m_r1 = (ce || ce_mask) ? 1 : 0;
    it.v = e; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic cyc(input logic c, input logic cm, input logic e, input logic em,
                     input logic [2:0] d, input string req);
    @(posedge clk);
    #2;
    clr = c; clr_mask = cm; ce = e; ce_mask = em; div_code = d;
    model_push(req);
  endtask

  task automatic run_code(input int code);
    string rq;
    rq = (code == 0) ? "R3" : "R2";
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 3'(code), "R1");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'(code), "R4");
    for (int i = 0; i < 2 * (code + 1) + 4; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'(code), rq);
  endtask

  // Monitor: one expected item per cycle, sampled after the rising edge.
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk(clk_out, it.v, it.req);
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): expired, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    m_s1 = 0; m_s2 = 0; m_r1 = 0; m_r2 = 0; m_n = 1; m_ph = 0;
    rst_n = 1'b0; clr = 1'b1; clr_mask = 1'b0; ce = 1'b1; ce_mask = 1'b0; div_code = 3'd0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(clk_out, 1'b0, "R1 reset");
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    model_push("R1");

    // R2 / R3 / R4: every ratio code from a fresh clear release
    for (int c = 0; c < 8; c++) run_code(c);

    // R5 / R6: freeze at differing phases of an odd ratio, then resume
    run_code(4);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, "R5");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd4, "R6");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, "R5");
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd4, "R6");
    run_code(5);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 3'd5, "R5");
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, "R6");

    // R7: mask keeps the divider running with the enable low
    run_code(2);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 3'd2, "R7");

    // R8: masked clear has no effect on period or phase
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 3'd2, "R8");

    // R9: ratio changes mid-period take effect at the wrap
    run_code(7);
    for (int i = 0; i < 3; i++)  cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd7, "R9");
    for (int i = 0; i < 14; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd2, "R9");
    for (int i = 0; i < 6; i++)  cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R9");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, "R9");

    // R10: ratio 1 frozen stays low
    run_code(0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R10");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R3");

    // R1: clear during a high pass-through phase drops the output at once
    @(posedge clk); #2;
    clr = 1'b1; clr_mask = 1'b0;
    #0.3;
    chk(clk_out, 1'b0, "R1 async clear");
    model_push("R1");
    run_code(3);

    repeat (4) @(posedge clk);
    #3;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule